// File: doc/BRIEF.md
# Flash Fast-Program Command Interface

This block is the device-side command decoder of a parallel NOR flash array for two fast-program commands. A double-word command takes a setup write and then two word writes. An octuple-byte command takes a setup write and then eight byte writes, and is valid only in byte mode. The address and data of each write are collected into a four-word page buffer. The block checks that the addresses share one page, that the bus mode suits the command, and that the high-voltage enable input is present where it is needed. Only when all three checks pass does the last write start an internal program controller.

The program controller is a busy counter of configurable length. When it finishes, it ANDs the page buffer into the array, so programming can only clear bits. Unwritten page slots hold all ones and leave their words unchanged. While the controller runs, reads return a status byte. After a clean finish, reads return array data again. A failed check programs nothing, and the read path keeps showing status until a read/reset command arrives.

The status byte sits in `rd_data[7:0]`, and `rd_data[15:8]` is zero while status is shown. Its bit 7 is high when the block is ready. Bit 5 is the error flag. Bits 1:0 hold the cause: 1 for a page mismatch, 2 for a missing high voltage and 3 for a wrong bus mode. When several faults occur together, mode wins over voltage, and voltage wins over the page check.

Top module: `flash_pgm_if`

## Requirements
- R1: After reset every array word reads 0xFFFF and `ready` is 1.
- R2: A write of low byte 0x50, then two word writes whose word addresses are equal except in bit 0, in word mode, programs both words. `ready` falls after the third write and stays low for exactly BUSY_CYC clock cycles. The words then read their old value AND the written data.
- R3: A write of low byte 0x8B, then eight byte writes in byte mode with `vpp_high` = 1, programs the eight bytes. The byte address is {`bus_addr`, `bus_bsel`}, and `bus_bsel` = 0 selects the low byte. `ready` stays 1 up to the eighth byte write and falls only after the ninth write.
- R4: Programming never turns a stored 0 into a 1.
- R5: In a double-word command, if the two word addresses differ in any bit above bit 0, nothing is programmed and reads return status 0x00A1.
- R6: In an octuple-byte command, if any byte has word-address bits above bit 1 that differ from those of the first byte, nothing is programmed and reads return status 0x00A1.
- R7: An octuple-byte command with `vpp_high` = 0 on its last write programs nothing and reads return 0x00A2. With DW_NEED_VPP = 0 (the default), a double-word command programs without `vpp_high`.
- R8: An octuple-byte command with `byte_mode` = 0, or a double-word command with `byte_mode` = 1, during any of its writes programs nothing and reads return 0x00A3.
- R9: While an error is shown, every write other than low byte 0xF0 is ignored and status stays on the read path. A 0xF0 write restores array reads with the array unchanged.
- R10: In read mode, a write whose low byte is not 0x50 or 0x8B is ignored, including 0xF0, and the array stays unchanged.
- R11: Writes issued while `ready` is 0 are ignored. They start no command and change no data.
- R12: While the controller runs, reads return 0x0000, whose bit 7 of 0 means busy. In byte mode, array reads return the selected byte in `rd_data[7:0]` with zero above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_bsel | input | 1 | Byte select in byte mode (0 = low byte) |
| wr_data | input | 16 | Write data; the command code is in bits 7:0 |
| byte_mode | input | 1 | 1 = byte bus mode, 0 = word bus mode |
| vpp_high | input | 1 | High-voltage enable level present |
| rd_data | output | 16 | Array data or status word |
| ready | output | 1 | 0 while the program controller runs |

## Verification
The assertions assume that `byte_mode` and `vpp_high` are driven to known levels whenever `wr_en` is high. They also assume that `wr_en` is a single-cycle strobe with stable address and data around the clock edge. The bench honours this by changing every input at the falling edge and by setting the mode and voltage levels only between commands, except in the cases that deliberately fault them. Reads are sampled one nanosecond after a falling edge, well away from the active edge.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    localparam int WORD_W     = 16;
    localparam int PAGE_WORDS = 4;
    localparam int SLOT_W     = $clog2(PAGE_WORDS);

    localparam logic [7:0] CODE_DWORD = 8'h50;
    localparam logic [7:0] CODE_OCT   = 8'h8B;
    localparam logic [7:0] CODE_RESET = 8'hF0;

    typedef logic [PAGE_WORDS-1:0][WORD_W-1:0] page_t;

    typedef enum logic [2:0] {
        ST_READ,
        ST_DW_1,
        ST_DW_2,
        ST_OCT,
        ST_PROG,
        ST_ERR
    } seq_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_ADJ  = 2'd1,
        CAUSE_VPP  = 2'd2,
        CAUSE_MODE = 2'd3
    } err_cause_t;

    typedef struct packed {
        logic       ready;
        logic       rsv6;
        logic       err;
        logic [2:0] rsv;
        err_cause_t cause;
    } status_t;

    // Mode fault outranks voltage, voltage outranks page mismatch
    function automatic err_cause_t pick_cause(logic mode_bad, logic vpp_bad, logic adj_bad);
        if (mode_bad)     return CAUSE_MODE;
        else if (vpp_bad) return CAUSE_VPP;
        else if (adj_bad) return CAUSE_ADJ;
        else              return CAUSE_NONE;
    endfunction

    function automatic status_t make_status(logic rdy, err_cause_t c);
        status_t s;
        s.ready = rdy;
        s.rsv6  = 1'b0;
        s.err   = (c != CAUSE_NONE);
        s.rsv   = 3'b000;
        s.cause = c;
        return s;
    endfunction

endpackage

// File: rtl/fpc_cmd_seq.sv
module fpc_cmd_seq
    import fpc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter bit DW_NEED_VPP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_bsel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              byte_mode,
    input  logic              vpp_high,
    input  logic              pgm_busy,
    input  logic              pgm_done,
    output logic              start,
    output page_t             page,
    output logic [ADDR_W-3:0] page_base,
    output logic              status_show,
    output status_t           status
);

    localparam int OCT_LAST = 7;

    seq_state_t        state;
    logic [2:0]        oct_cnt;
    logic [ADDR_W-1:0] first_addr;
    logic              mode_bad;
    logic              adj_bad;
    err_cause_t        err_cause;

    logic              fin;
    logic              mode_now;
    logic              adj_now;
    logic              vpp_now;
    err_cause_t        cause_now;
    logic [SLOT_W-1:0] slot;

    assign slot = wr_addr[SLOT_W-1:0];

    always_comb begin
        fin      = 1'b0;
        mode_now = mode_bad;
        adj_now  = adj_bad;
        vpp_now  = 1'b0;
        case (state)
            ST_DW_2: begin
                fin      = wr_en;
                mode_now = mode_bad | byte_mode;
                adj_now  = (wr_addr[ADDR_W-1:1] != first_addr[ADDR_W-1:1]);
                vpp_now  = DW_NEED_VPP && !vpp_high;
            end
            ST_OCT: begin
                fin      = wr_en && (oct_cnt == 3'(OCT_LAST));
                mode_now = mode_bad | !byte_mode;
                adj_now  = adj_bad | (wr_addr[ADDR_W-1:2] != first_addr[ADDR_W-1:2]);
                vpp_now  = !vpp_high;
            end
            default: ;
        endcase
        cause_now = pick_cause(mode_now, vpp_now, adj_now);
        start     = fin && (cause_now == CAUSE_NONE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_READ;
            oct_cnt    <= '0;
            first_addr <= '0;
            mode_bad   <= 1'b0;
            adj_bad    <= 1'b0;
            err_cause  <= CAUSE_NONE;
            page       <= '1;
        end else begin
            case (state)
                ST_READ: begin
                    if (wr_en && wr_data[7:0] == CODE_DWORD) begin
                        state    <= ST_DW_1;
                        mode_bad <= byte_mode;
                        adj_bad  <= 1'b0;
                        page     <= '1;
                    end else if (wr_en && wr_data[7:0] == CODE_OCT) begin
                        state    <= ST_OCT;
                        oct_cnt  <= '0;
                        mode_bad <= !byte_mode;
                        adj_bad  <= 1'b0;
                        page     <= '1;
                    end
                end
                ST_DW_1: begin
                    if (wr_en) begin
                        first_addr  <= wr_addr;
                        page[slot]  <= wr_data;
                        mode_bad    <= mode_bad | byte_mode;
                        state       <= ST_DW_2;
                    end
                end
                ST_DW_2: begin
                    if (wr_en) begin
                        page[slot] <= wr_data;
                        if (start) begin
                            state <= ST_PROG;
                        end else begin
                            state     <= ST_ERR;
                            err_cause <= cause_now;
                        end
                    end
                end
                ST_OCT: begin
                    if (wr_en) begin
                        if (wr_bsel) page[slot][15:8] <= wr_data[7:0];
                        else         page[slot][7:0]  <= wr_data[7:0];
                        mode_bad <= mode_now;
                        if (oct_cnt == '0) begin
                            first_addr <= wr_addr;
                            adj_bad    <= 1'b0;
                        end else begin
                            adj_bad <= adj_now;
                        end
                        oct_cnt <= oct_cnt + 3'd1;
                        if (fin) begin
                            if (start) begin
                                state <= ST_PROG;
                            end else begin
                                state     <= ST_ERR;
                                err_cause <= cause_now;
                            end
                        end
                    end
                end
                ST_PROG: begin
                    if (pgm_done) state <= ST_READ;
                end
                ST_ERR: begin
                    if (wr_en && wr_data[7:0] == CODE_RESET) begin
                        state     <= ST_READ;
                        err_cause <= CAUSE_NONE;
                    end
                end
                default: state <= ST_READ;
            endcase
        end
    end

    assign page_base   = first_addr[ADDR_W-1:2];
    assign status_show = (state == ST_PROG) || (state == ST_ERR);
    assign status      = make_status(!pgm_busy,
                                     (state == ST_ERR) ? err_cause : CAUSE_NONE);

    AST_ERR_NO_START: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERR) |-> !start); // R9

    AST_OCT_NEEDS_VPP: assert property (@(posedge clk) disable iff (rst)
        (start && state == ST_OCT) |-> (vpp_high && byte_mode)); // R7

    AST_DW_WORD_MODE: assert property (@(posedge clk) disable iff (rst)
        (start && state == ST_DW_2) |-> !byte_mode); // R8

endmodule

// File: rtl/fpc_pgm_ctrl.sv
module fpc_pgm_ctrl #(
    parameter int BUSY_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(BUSY_CYC + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CNT_W'(BUSY_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CNT_W'(1));

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy); // R11

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R2

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R2

endmodule

// File: rtl/fpc_array.sv
module fpc_array
    import fpc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  page_t             page,
    input  logic [ADDR_W-3:0] page_base,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++) mem[w] <= '1;
        end else if (commit) begin
            for (int s = 0; s < PAGE_WORDS; s++) begin
                mem[{page_base, SLOT_W'(s)}] <= mem[{page_base, SLOT_W'(s)}] & page[s];
            end
        end
    end

    assign rd_word = mem[rd_addr];

    for (genvar g = 0; g < DEPTH; g++) begin : g_and_chk
        AST_AND_ONLY: assert property (@(posedge clk) disable iff (rst)
            (mem[g] & ~$past(mem[g])) == '0); // R4
    end

endmodule

// File: rtl/flash_pgm_if.sv
module flash_pgm_if
    import fpc_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int BUSY_CYC    = 8,
    parameter bit DW_NEED_VPP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_bsel,
    input  logic [15:0]       wr_data,
    input  logic              byte_mode,
    input  logic              vpp_high,
    output logic [15:0]       rd_data,
    output logic              ready
);

    logic              start;
    logic              busy;
    logic              done;
    page_t             page;
    logic [ADDR_W-3:0] page_base;
    logic              status_show;
    status_t           status;
    logic [WORD_W-1:0] rd_word;

    fpc_cmd_seq #(
        .ADDR_W      (ADDR_W),
        .DW_NEED_VPP (DW_NEED_VPP)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (bus_addr),
        .wr_bsel     (bus_bsel),
        .wr_data     (wr_data),
        .byte_mode   (byte_mode),
        .vpp_high    (vpp_high),
        .pgm_busy    (busy),
        .pgm_done    (done),
        .start       (start),
        .page        (page),
        .page_base   (page_base),
        .status_show (status_show),
        .status      (status)
    );

    fpc_pgm_ctrl #(
        .BUSY_CYC (BUSY_CYC)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .busy  (busy),
        .done  (done)
    );

    fpc_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .commit    (done),
        .page      (page),
        .page_base (page_base),
        .rd_addr   (bus_addr),
        .rd_word   (rd_word)
    );

    always_comb begin
        if (status_show)    rd_data = {8'h00, status};
        else if (byte_mode) rd_data = {8'h00, bus_bsel ? rd_word[15:8] : rd_word[7:0]};
        else                rd_data = rd_word;
    end

    assign ready = !busy;

    AST_BUSY_SHOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (rd_data == 16'h0000)); // R12

endmodule

// File: tb/flash_pgm_if_test.sv
`timescale 1ns/1ps
module flash_pgm_if_test;

    localparam int AW    = 4;
    localparam int BUSY  = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_bsel = 1'b0;
    logic [15:0]   wr_data = '0;
    logic          byte_mode = 1'b0;
    logic          vpp_high = 1'b0;
    logic [15:0]   rd_data;
    logic          ready;

    int checks = 0;
    int fails  = 0;
    logic [15:0] em [DEPTH];

    always #2.5 clk = ~clk;

    flash_pgm_if #(.ADDR_W(AW), .BUSY_CYC(BUSY), .DW_NEED_VPP(1'b0)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .bus_addr(bus_addr), .bus_bsel(bus_bsel),
        .wr_data(wr_data), .byte_mode(byte_mode), .vpp_high(vpp_high),
        .rd_data(rd_data), .ready(ready)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [AW-1:0] a, logic b, logic [15:0] d);
        bus_addr = a; bus_bsel = b; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic b, output logic [15:0] d);
        bus_addr = a; bus_bsel = b;
        #1 d = rd_data;
        @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_word(string tag, logic [AW-1:0] a);
        logic [15:0] d;
        rd(a, 1'b0, d);
        check(tag, d, em[a]);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 ready after reset", {15'd0, ready}, 16'd1);
        for (int w = 0; w < DEPTH; w += 5) begin
            rd(AW'(w), 1'b0, d);
            check("R1 erased word", d, 16'hFFFF);
        end
    endtask

    task automatic t_dword();
        int n;
        logic [15:0] d;
        byte_mode = 1'b0; vpp_high = 1'b0;
        bus_wr(4'd0, 1'b0, 16'h0050);
        bus_wr(4'd4, 1'b0, 16'h1234);
        check("R2 ready before last word", {15'd0, ready}, 16'd1);
        bus_wr(4'd5, 1'b0, 16'hABCD);
        #1 check("R12 status while busy", rd_data, 16'h0000);
        wait_ready(n);
        check("R2 busy length", 16'(n), 16'(BUSY));
        em[4] &= 16'h1234; em[5] &= 16'hABCD;
        check_word("R2 first word", 4'd4);
        check_word("R7 second word without vpp", 4'd5);
        check_word("R2 neighbour untouched", 4'd6);
    endtask

    task automatic t_and();
        int n;
        bus_wr(4'd0, 1'b0, 16'h0050);
        bus_wr(4'd5, 1'b0, 16'h0FF0);
        bus_wr(4'd4, 1'b0, 16'hFF00);
        wait_ready(n);
        em[4] &= 16'hFF00; em[5] &= 16'h0FF0;
        check_word("R4 word 4 only clears", 4'd4);
        check_word("R4 word 5 only clears", 4'd5);
    endtask

    task automatic t_oct();
        int n;
        logic [15:0] d;
        byte_mode = 1'b1; vpp_high = 1'b1;
        bus_wr(4'd0, 1'b0, 16'h008B);
        for (int i = 0; i < 8; i++) begin
            int k;
            logic [7:0] v;
            k = (i * 5) % 8;
            v = 8'h3C ^ 8'(i * 17);
            if (i == 7) check("R3 ready before ninth write", {15'd0, ready}, 16'd1);
            bus_wr(AW'(8 + k / 2), k[0], {8'hFF, v});
            if (k[0]) em[8 + k / 2][15:8] &= v;
            else      em[8 + k / 2][7:0]  &= v;
        end
        check("R3 busy after ninth write", {15'd0, ready}, 16'd0);
        wait_ready(n);
        check("R3 busy length", 16'(n), 16'(BUSY));
        rd(4'd9, 1'b1, d);
        check("R12 byte read high", d, {8'h00, em[9][15:8]});
        rd(4'd10, 1'b0, d);
        check("R12 byte read low", d, {8'h00, em[10][7:0]});
        byte_mode = 1'b0;
        for (int w = 8; w < 12; w++) check_word("R3 octuple word", AW'(w));
        check_word("R3 outside page", 4'd12);
    endtask

    task automatic t_dw_adj();
        logic [15:0] d;
        byte_mode = 1'b0;
        bus_wr(4'd0, 1'b0, 16'h0050);
        bus_wr(4'd2, 1'b0, 16'h0000);
        bus_wr(4'd4, 1'b0, 16'h0000);
        rd(4'd2, 1'b0, d);
        check("R5 adjacency status", d, 16'h00A1);
        check("R5 no busy", {15'd0, ready}, 16'd1);
        bus_wr(4'd0, 1'b0, 16'h0050);
        bus_wr(4'd2, 1'b0, 16'h008B);
        rd(4'd2, 1'b0, d);
        check("R9 error holds", d, 16'h00A1);
        bus_wr(4'd0, 1'b0, 16'h00F0);
        check_word("R9 array back, word 2", 4'd2);
        check_word("R9 array back, word 4", 4'd4);
    endtask

    task automatic t_oct_fault(logic bm, logic vp, int bad_word, logic [15:0] exp, string tag);
        logic [15:0] d;
        byte_mode = bm; vpp_high = vp;
        bus_wr(4'd0, 1'b0, 16'h008B);
        for (int i = 0; i < 8; i++)
            bus_wr((i == 3) ? AW'(bad_word) : AW'(i / 2), i[0], 16'h0000);
        rd(4'd0, 1'b0, d);
        check(tag, d, exp);
        bus_wr(4'd0, 1'b0, 16'h00F0);
        byte_mode = 1'b0;
        check_word(tag, 4'd0);
        check_word(tag, 4'd1);
    endtask

    task automatic t_dw_byte_mode();
        logic [15:0] d;
        byte_mode = 1'b1;
        bus_wr(4'd0, 1'b0, 16'h0050);
        bus_wr(4'd0, 1'b0, 16'h0000);
        bus_wr(4'd1, 1'b0, 16'h0000);
        rd(4'd0, 1'b0, d);
        check("R8 dword in byte mode", d, 16'h00A3);
        bus_wr(4'd0, 1'b0, 16'h00F0);
        byte_mode = 1'b0;
        check_word("R8 dword byte mode array", 4'd0);
    endtask

    task automatic t_ignore();
        byte_mode = 1'b0;
        bus_wr(4'd0, 1'b0, 16'h0077);
        bus_wr(4'd0, 1'b0, 16'h0000);
        bus_wr(4'd1, 1'b0, 16'h0000);
        check_word("R10 unknown code", 4'd0);
        check_word("R10 unknown code next", 4'd1);
        bus_wr(4'd4, 1'b0, 16'h00F0);
        check_word("R10 reset in read mode", 4'd4);
        check("R10 still ready", {15'd0, ready}, 16'd1);
    endtask

    task automatic t_busy();
        int n;
        byte_mode = 1'b0; vpp_high = 1'b0;
        bus_wr(4'd0, 1'b0, 16'h0050);
        bus_wr(4'd0, 1'b0, 16'hAAAA);
        bus_wr(4'd1, 1'b0, 16'h5555);
        bus_wr(4'd0, 1'b0, 16'h0050);
        bus_wr(4'd0, 1'b0, 16'h0000);
        bus_wr(4'd1, 1'b0, 16'h0000);
        wait_ready(n);
        em[0] &= 16'hAAAA; em[1] &= 16'h5555;
        check_word("R11 word 0 after busy writes", 4'd0);
        check_word("R11 word 1 after busy writes", 4'd1);
        check("R11 ready afterwards", {15'd0, ready}, 16'd1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        for (int w = 0; w < DEPTH; w++) em[w] = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dword();
        t_and();
        t_oct();
        t_dw_adj();
        t_oct_fault(1'b1, 1'b1, 5, 16'h00A1, "R6 octuple adjacency");
        t_oct_fault(1'b1, 1'b0, 1, 16'h00A2, "R7 octuple without vpp");
        t_oct_fault(1'b0, 1'b1, 1, 16'h00A3, "R8 octuple in word mode");
        t_dw_byte_mode();
        t_ignore();
        t_busy();
        report();
    end

endmodule